// File: doc/BRIEF.md
# Exception Return Status Restore

This block computes the processor state that follows a return from an exception handler or from a non-maskable interrupt handler. The status word holds several stacked privilege and pending levels. On a return the block pops one level: the two most significant bits are kept, and the lower 28-bit field is shifted down by ten positions. The pending flag is then set from the state that was in force before the pop. A return from the non-maskable path also forces the mask flag on.

The pop may land the core in user mode. In that case the block swaps stacks. The current stack pointer goes out as the kernel stack pointer to be saved, with a one-cycle write enable. The saved user stack pointer becomes the new stack pointer. Fetching the return address and jumping to it are outside this block.

All outputs are registered. They change only on a clock edge where the return strobe is high.

Top module: `exr_status_restore`

## Requirements
- R1: On a return, the new status word is built as follows: bits [31:30] are the old bits [31:30], bits [29:18] are zero, and bits [17:0] are the old bits [27:10]. Flag bits 7 and 30 may then be overridden as given by R4 and R5.
- R2: When bit 6 (user mode) of the shifted word is set, which is old bit 16, the return swaps stacks. The new SP equals `usp_in`, `ksp_out` equals `sp_in`, and `ksp_we` is 1.
- R3: When the shifted user-mode bit is clear, the new SP equals `sp_in`, `ksp_we` is 0, and `ksp_out` keeps its value.
- R4: Status bit 7 (pending) is forced to 1 when old bit 8 (restart) was 0. Otherwise bit 7 keeps its shifted value, which is old bit 17.
- R5: A return with `ret_is_nmi`=1 always sets status bit 30 (mask).
- R6: A return with `ret_is_nmi`=0 does not force bit 30. It keeps old bit 30.
- R7: While `ret_valid` is 0, `stat_out`, `sp_out` and `ksp_out` hold their values and `ksp_we` is 0.
- R8: While reset (`rst_n`=0) is asserted, all outputs are zero.
- R9: `ksp_we` is high for exactly the one cycle after a swapping return. It falls on the next edge unless another swapping return occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Return instruction strobe |
| ret_is_nmi | input | 1 | 1 = return from NMI, 0 = return from exception |
| stat_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | Saved user stack pointer |
| stat_out | output | 32 | Restored status word |
| sp_out | output | 32 | New stack pointer |
| ksp_out | output | 32 | Kernel stack pointer value to save |
| ksp_we | output | 1 | Kernel stack pointer save strobe |

## Verification
A wrong shift amount or a wrong kept-bit mask corrupts `stat_out` on the first edge after any return, so it is caught at once. A mixup between the user-mode position and the restart position shows up on the same edge in two places: as a wrong `ksp_we` and `sp_out`, or as a wrong pending bit. A missing hold shows on the first idle cycle as drift on `stat_out` or `sp_out`. A stuck save strobe shows one cycle after a swap.

// File: rtl/exr_pkg.sv
package exr_pkg;
   typedef enum logic {
      RET_EXC = 1'b0,
      RET_NMI = 1'b1
   } ret_kind_e;

   localparam int unsigned DEF_WORD_W  = 32;
   localparam int unsigned DEF_KEEP_HI = 2;
   localparam int unsigned DEF_FIELD_W = 28;
   localparam int unsigned DEF_SHIFT   = 10;
endpackage

// File: rtl/exr_level_pop.sv
module exr_level_pop #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned KEEP_HI = 2,
   parameter int unsigned FIELD_W = 28,
   parameter int unsigned SHIFT   = 10
) (
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] word_out
);
   localparam int unsigned LIVE_W   = FIELD_W - SHIFT;
   localparam int unsigned KEEP_LSB = WORD_W - KEEP_HI;

   generate
      if (KEEP_HI + FIELD_W > WORD_W) begin : g_bad_split
         $error("kept bits and field overlap");
      end
      if (SHIFT >= FIELD_W) begin : g_bad_shift
         $error("shift must be smaller than field");
      end
   endgenerate

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (i >= KEEP_LSB) begin : g_keep
         assign word_out[i] = word_in[i];
      end else if (i < LIVE_W) begin : g_move
         assign word_out[i] = word_in[i+SHIFT];
      end else begin : g_clear
         assign word_out[i] = 1'b0;
      end
   end
endmodule

// File: rtl/exr_flag_merge.sv
module exr_flag_merge #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned P_POS   = 7,
   parameter int unsigned R_POS   = 8,
   parameter int unsigned M_POS   = 30,
   parameter bit          NMI_SETS_M = 1'b1
) (
   input  logic [WORD_W-1:0] popped,
   input  logic              prior_r,
   input  exr_pkg::ret_kind_e kind,
   output logic [WORD_W-1:0] merged
);
   logic [WORD_W-1:0] with_p;

   generate
      if (P_POS >= WORD_W || R_POS >= WORD_W || M_POS >= WORD_W) begin : g_bad_pos
         $error("flag position outside word");
      end
      if (P_POS == M_POS) begin : g_bad_pm
         $error("pending and mask flags collide");
      end
   endgenerate

   always_comb begin
      with_p = popped;
      if (!prior_r) with_p[P_POS] = 1'b1;
   end

   generate
      if (NMI_SETS_M) begin : g_force_m
         always_comb begin
            merged = with_p;
            if (kind == exr_pkg::RET_NMI) merged[M_POS] = 1'b1;
         end
      end else begin : g_plain
         assign merged = with_p;
      end
   endgenerate
endmodule

// File: rtl/exr_stack_swap.sv
module exr_stack_swap #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned U_POS  = 6
) (
   input  logic [WORD_W-1:0] popped,
   input  logic [WORD_W-1:0] cur_sp,
   input  logic [WORD_W-1:0] user_sp,
   output logic              to_user,
   output logic [WORD_W-1:0] next_sp
);
   generate
      if (U_POS >= WORD_W) begin : g_bad_u
         $error("user flag outside word");
      end
   endgenerate

   assign to_user = popped[U_POS];
   assign next_sp = to_user ? user_sp : cur_sp;
endmodule

// File: rtl/exr_status_restore.sv
module exr_status_restore #(
   parameter int unsigned WORD_W  = exr_pkg::DEF_WORD_W,
   parameter int unsigned KEEP_HI = exr_pkg::DEF_KEEP_HI,
   parameter int unsigned FIELD_W = exr_pkg::DEF_FIELD_W,
   parameter int unsigned SHIFT   = exr_pkg::DEF_SHIFT,
   parameter int unsigned U_POS   = 6,
   parameter int unsigned P_POS   = 7,
   parameter int unsigned R_POS   = 8,
   parameter int unsigned M_POS   = 30,
   parameter bit          NMI_SETS_M = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_valid,
   input  logic              ret_is_nmi,
   input  logic [WORD_W-1:0] stat_in,
   input  logic [WORD_W-1:0] sp_in,
   input  logic [WORD_W-1:0] usp_in,
   output logic [WORD_W-1:0] stat_out,
   output logic [WORD_W-1:0] sp_out,
   output logic [WORD_W-1:0] ksp_out,
   output logic              ksp_we
);
   logic [WORD_W-1:0]  popped;
   logic [WORD_W-1:0]  merged;
   logic [WORD_W-1:0]  next_sp;
   logic               to_user;
   exr_pkg::ret_kind_e kind;

   assign kind = ret_is_nmi ? exr_pkg::RET_NMI : exr_pkg::RET_EXC;

   exr_level_pop #(
      .WORD_W(WORD_W), .KEEP_HI(KEEP_HI), .FIELD_W(FIELD_W), .SHIFT(SHIFT)
   ) u_pop (
      .word_in(stat_in), .word_out(popped)
   );

   exr_flag_merge #(
      .WORD_W(WORD_W), .P_POS(P_POS), .R_POS(R_POS), .M_POS(M_POS),
      .NMI_SETS_M(NMI_SETS_M)
   ) u_flags (
      .popped(popped), .prior_r(stat_in[R_POS]), .kind(kind), .merged(merged)
   );

   exr_stack_swap #(
      .WORD_W(WORD_W), .U_POS(U_POS)
   ) u_swap (
      .popped(popped), .cur_sp(sp_in), .user_sp(usp_in),
      .to_user(to_user), .next_sp(next_sp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_out <= '0;
         sp_out   <= '0;
         ksp_out  <= '0;
         ksp_we   <= 1'b0;
      end else begin
         ksp_we <= ret_valid & to_user;
         if (ret_valid) begin
            stat_out <= merged;
            sp_out   <= next_sp;
            if (to_user) ksp_out <= sp_in;
         end
      end
   end
endmodule

// File: rtl/exr_status_restore_chk.sv
module exr_status_restore_chk #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned SHIFT  = 10,
   parameter int unsigned U_POS  = 6,
   parameter int unsigned P_POS  = 7,
   parameter int unsigned R_POS  = 8,
   parameter int unsigned M_POS  = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ret_valid,
   input logic              ret_is_nmi,
   input logic [WORD_W-1:0] stat_in,
   input logic [WORD_W-1:0] sp_in,
   input logic [WORD_W-1:0] usp_in,
   input logic [WORD_W-1:0] stat_out,
   input logic [WORD_W-1:0] sp_out,
   input logic [WORD_W-1:0] ksp_out,
   input logic              ksp_we
);
   AST_SWAP_LOADS_USER_SP: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && stat_in[U_POS+SHIFT] |=> ksp_we && sp_out == $past(usp_in) && ksp_out == $past(sp_in)); // R2
   AST_NO_SWAP_KEEPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && !stat_in[U_POS+SHIFT] |=> !ksp_we && sp_out == $past(sp_in) && $stable(ksp_out)); // R3
   AST_PENDING_FROM_PRIOR_R: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && !stat_in[R_POS] |=> stat_out[P_POS]); // R4
   AST_NMI_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && ret_is_nmi |=> stat_out[M_POS]); // R5
   AST_EXC_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && !ret_is_nmi |=> stat_out[M_POS] == $past(stat_in[M_POS])); // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_valid |=> $stable(stat_out) && $stable(sp_out) && $stable(ksp_out) && !ksp_we); // R7
   AST_WE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      ksp_we && !ret_valid |=> !ksp_we); // R9
endmodule

bind exr_status_restore exr_status_restore_chk u_chk (.*);

// File: tb/exr_status_restore_test.sv
module exr_status_restore_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ret_valid = 1'b0;
   logic        ret_is_nmi = 1'b0;
   logic [31:0] stat_in = '0, sp_in = '0, usp_in = '0;
   logic [31:0] stat_out, sp_out, ksp_out;
   logic        ksp_we;

   int checks = 0;
   int fails  = 0;
   logic [31:0] e_stat = '0, e_sp = '0, e_ksp = '0;
   logic        e_we = 1'b0;

   always #10 clk = ~clk;

   exr_status_restore uut (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_is_nmi(ret_is_nmi),
      .stat_in(stat_in), .sp_in(sp_in), .usp_in(usp_in),
      .stat_out(stat_out), .sp_out(sp_out), .ksp_out(ksp_out), .ksp_we(ksp_we)
   );

   function automatic logic [31:0] pop_word(input logic [31:0] w);
      return {w[31:30], 12'b0, w[27:10]};
   endfunction

   function automatic logic [31:0] restore(input logic [31:0] w, input logic nmi);
      logic [31:0] r;
      r = pop_word(w);
      if (!w[8]) r[7] = 1'b1;
      if (nmi) r[30] = 1'b1;
      return r;
   endfunction

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at negedge, model the edge, check at following negedge
   task automatic step(input logic v, input logic nmi, input logic [31:0] st,
                       input logic [31:0] sp, input logic [31:0] usp);
      string sreq, preq;
      ret_valid = v; ret_is_nmi = nmi; stat_in = st; sp_in = sp; usp_in = usp;
      if (v) begin
         e_stat = restore(st, nmi);
         e_we   = pop_word(st)[6];
         e_sp   = e_we ? usp : sp;
         if (e_we) e_ksp = sp;
         sreq = !st[8] ? "R4" : (nmi ? "R5" : "R6");
         preq = e_we ? "R2" : "R3";
      end else begin
         e_we = 1'b0;
         sreq = "R7"; preq = "R7";
      end
      @(negedge clk);
      check32(sreq, stat_out, e_stat);
      check32("R1", {stat_out[31], stat_out[29:8], stat_out[6:0]},
              {e_stat[31], e_stat[29:8], e_stat[6:0]});
      check32(preq, sp_out, e_sp);
      check32(preq, ksp_out, e_ksp);
      check32(v ? preq : "R9", {31'b0, ksp_we}, {31'b0, e_we});
   endtask

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      check32("R8", stat_out, '0);
      check32("R8", sp_out, '0);
      check32("R8", ksp_out, '0);
      check32("R8", {31'b0, ksp_we}, '0);
      rst_n = 1'b1;
      // directed corners
      step(1, 0, 32'hFFFF_FFFF, 32'h1000, 32'h2000); // R restart set, U swap, exc
      step(0, 0, 32'h0, 32'h5, 32'h6);               // R9 pulse falls, R7 hold
      step(1, 1, 32'h0001_0000, 32'h3000, 32'h4000); // swap, NMI, P forced
      step(1, 0, 32'h4000_0100, 32'h3333, 32'h4444); // no swap, M kept, R set
      step(1, 1, 32'h0000_0000, 32'h7777, 32'h8888); // zero word
      step(1, 0, 32'h3000_03FF, 32'h9, 32'hA);       // bits 29:28 dropped
      for (int n = 0; n < 400; n++) begin
         step(($urandom % 4) != 0, $urandom % 2, $urandom, $urandom, $urandom);
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule